// File: doc/BRIEF.md
# Dual-Mode Fractional/Integer Multiplier

This block is the multiply stage of a DSP datapath. It accepts two 16-bit operands, each with its own signedness flag, and builds a 17-bit two's complement value from each one. A single 17x17 signed array then forms the product, so signed, unsigned and mixed-sign multiplies all use the same hardware. A scaler turns the product into a 33-bit value. In fractional mode that value is a 1.31 (Q31) result, and in integer mode it is the plain product. The 33-bit value is sign-extended to 40 bits so that an accumulator can take it directly.

A second output carries the result of a microcontroller-style integer multiply. In byte mode, only the low 8 bits of each operand take part and the result is 16 bits wide. In word mode, the result is 32 bits wide. Both results are registered. A result appears one clock after an input is marked valid and holds until the next valid input arrives.

Top module: `mulq_top`

## Requirements
- R1: `res_valid` equals the value that `in_valid` had on the previous clock edge. A result registered from inputs at edge N is visible after edge N.
- R2: While `in_valid` is low, `acc_res` and `mcu_res` keep their values no matter how the other inputs change.
- R3: A synchronous active-high `rst` clears `res_valid`, `acc_res` and `mcu_res` to zero.
- R4: In word mode (`size_byte`=0), each operand is extended to 17 bits. When its flag is 1 the extension copies bit 15, and when its flag is 0 the extension adds a zero. In integer mode, `acc_res` then equals the exact product of the two extended values, whether both operands are signed, both are unsigned, or the signs are mixed.
- R5: In byte mode (`size_byte`=1), only bits 7:0 of each operand are used. Each is extended from bit 7 when its flag is 1 and zero-extended when its flag is 0. Operand bits 15:8 have no effect on either output.
- R6: In fractional mode (`frac_en`=1), the scaled value is the product shifted left by one and kept to 33 bits, so bit 0 of `acc_res` is 0. As an example, 0x8000 x 0x8000 with both operands signed gives `acc_res` = 0x0080000000 (+1.0).
- R7: Bits 39:33 of `acc_res` always equal bit 32, which is the sign bit of the 33-bit scaled value.
- R8: `mcu_res` is never scaled by `frac_en`. In word mode it holds bits 31:0 of the product. In byte mode it holds bits 15:0 of the product in its bits 15:0, and its bits 31:16 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and modes are valid this cycle |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| opa_signed | input | 1 | 1: first operand is signed |
| opb_signed | input | 1 | 1: second operand is signed |
| frac_en | input | 1 | 1: fractional (Q31) scaling, 0: integer |
| size_byte | input | 1 | 1: byte operands, 0: word operands |
| res_valid | output | 1 | Registered results are fresh |
| acc_res | output | 40 | Scaled product, sign-extended for the accumulator |
| mcu_res | output | 32 | Integer multiply result (16 or 32 bits used) |

## Verification
The assertions assume that `in_valid` and the mode inputs are known at every clock edge after reset. They also assume that the fractional-mode check is meaningful only for cycles that carried a valid input, and that is the only time they examine results. The stimulus changes inputs only on falling edges. It keeps the mode flags at defined 0/1 values, and it drives random data on the operands during idle cycles so that the hold rule is exercised. Fractional mode is also given unsigned operands, and the bench expects the product to wrap to 33 bits in that case.

// File: rtl/mulq_pkg.sv
package mulq_pkg;
  typedef struct packed {
    logic frac;
    logic byte_sel;
  } mulq_mode_t;

  typedef enum logic [0:0] {
    SCALE_INT  = 1'b0,
    SCALE_FRAC = 1'b1
  } mulq_scale_e;
endpackage

// File: rtl/mulq_operand_ext.sv
module mulq_operand_ext #(
  parameter int OP_W   = 16,
  parameter int BYTE_W = 8,
  localparam int EXT_W = OP_W + 1
) (
  input  logic [OP_W-1:0]  op,
  input  logic             is_signed,
  input  logic             byte_sel,
  output logic [EXT_W-1:0] ext
);
  logic fill_w;
  logic fill_b;

  always_comb begin
    fill_w = is_signed & op[OP_W-1];
    fill_b = is_signed & op[BYTE_W-1];
    if (byte_sel) ext = {{(EXT_W-BYTE_W){fill_b}}, op[BYTE_W-1:0]};
    else          ext = {fill_w, op};
  end
endmodule

// File: rtl/mulq_core.sv
module mulq_core #(
  parameter int EXT_W = 17,
  localparam int SCL_W = 2*EXT_W - 1
) (
  input  logic [EXT_W-1:0] a,
  input  logic [EXT_W-1:0] b,
  output logic [SCL_W-1:0] prod
);
  always_comb prod = SCL_W'($signed(a) * $signed(b));
endmodule

// File: rtl/mulq_scaler.sv
module mulq_scaler
  import mulq_pkg::*;
#(
  parameter int SCL_W = 33,
  parameter int ACC_W = 40
) (
  input  logic [SCL_W-1:0] prod,
  input  mulq_scale_e      scale,
  output logic [ACC_W-1:0] acc
);
  logic [SCL_W-1:0] scl;

  always_comb begin
    unique case (scale)
      SCALE_FRAC: scl = {prod[SCL_W-2:0], 1'b0};
      default:    scl = prod;
    endcase
    acc = {{(ACC_W-SCL_W){scl[SCL_W-1]}}, scl};
  end
endmodule

// File: rtl/mulq_top.sv
module mulq_top
  import mulq_pkg::*;
#(
  parameter int OP_W   = 16,
  parameter int BYTE_W = 8,
  parameter int ACC_W  = 40,
  localparam int EXT_W = OP_W + 1,
  localparam int SCL_W = 2*EXT_W - 1,
  localparam int MCU_W = 2*OP_W,
  localparam int BPR_W = 2*BYTE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  opa,
  input  logic [OP_W-1:0]  opb,
  input  logic             opa_signed,
  input  logic             opb_signed,
  input  logic             frac_en,
  input  logic             size_byte,
  output logic             res_valid,
  output logic [ACC_W-1:0] acc_res,
  output logic [MCU_W-1:0] mcu_res
);
  mulq_mode_t       mode;
  logic [OP_W-1:0]  ops   [2];
  logic             sgns  [2];
  logic [EXT_W-1:0] exts  [2];
  logic [SCL_W-1:0] prod;
  logic [ACC_W-1:0] acc_d;
  logic [MCU_W-1:0] mcu_d;

  assign mode    = '{frac: frac_en, byte_sel: size_byte};
  assign ops[0]  = opa;
  assign ops[1]  = opb;
  assign sgns[0] = opa_signed;
  assign sgns[1] = opb_signed;

  for (genvar i = 0; i < 2; i++) begin : g_ext
    mulq_operand_ext #(.OP_W(OP_W), .BYTE_W(BYTE_W)) u_ext (
      .op(ops[i]), .is_signed(sgns[i]), .byte_sel(mode.byte_sel), .ext(exts[i])
    );
  end

  mulq_core #(.EXT_W(EXT_W)) u_core (.a(exts[0]), .b(exts[1]), .prod(prod));

  mulq_scaler #(.SCL_W(SCL_W), .ACC_W(ACC_W)) u_scl (
    .prod(prod),
    .scale(mode.frac ? SCALE_FRAC : SCALE_INT),
    .acc(acc_d)
  );

  always_comb begin
    if (mode.byte_sel) mcu_d = {{(MCU_W-BPR_W){1'b0}}, prod[BPR_W-1:0]};
    else               mcu_d = prod[MCU_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      acc_res   <= '0;
      mcu_res   <= '0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        acc_res <= acc_d;
        mcu_res <= mcu_d;
      end
    end
  end

  assert_valid_follow_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);
  assert_valid_drop_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid);
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(acc_res) && $stable(mcu_res)));
  assert_uns_nonneg_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !opa_signed && !opb_signed && !frac_en) |=> !acc_res[ACC_W-1]);
  assert_byte_high_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_byte) |=> (mcu_res[MCU_W-1:BPR_W] == '0));
  assert_frac_lsb_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && frac_en) |=> !acc_res[0]);
  assert_sign_ext_R7: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (acc_res[ACC_W-1:SCL_W] == {(ACC_W-SCL_W){acc_res[SCL_W-1]}}));
endmodule

// File: tb/mulq_top_bench.sv
module mulq_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] opa = '0, opb = '0;
  logic        opa_signed = 1'b0, opb_signed = 1'b0, frac_en = 1'b0, size_byte = 1'b0;
  logic        res_valid;
  logic [39:0] acc_res;
  logic [31:0] mcu_res;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [39:0] last_acc = '0;
  logic [31:0] last_mcu = '0;

  always #5 clk = ~clk;

  mulq_top u_mulq_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opa(opa), .opb(opb),
    .opa_signed(opa_signed), .opb_signed(opb_signed), .frac_en(frac_en),
    .size_byte(size_byte), .res_valid(res_valid), .acc_res(acc_res), .mcu_res(mcu_res)
  );

  function automatic longint ext_val(input logic [15:0] v, input bit sg, input bit bt);
    longint r;
    if (bt) r = sg ? longint'($signed(v[7:0])) : longint'(v[7:0]);
    else    r = sg ? longint'($signed(v))      : longint'(v);
    return r;
  endfunction

  function automatic logic [39:0] exp_acc(input logic [15:0] a, input logic [15:0] b,
      input bit sa, input bit sb, input bit fr, input bit bt);
    longint p, s;
    p = ext_val(a, sa, bt) * ext_val(b, sb, bt);
    s = fr ? p * 2 : p;
    s = s & ((64'sd1 <<< 33) - 1);
    if (s[32]) s = s - (64'sd1 <<< 33);
    return s[39:0];
  endfunction

  function automatic logic [31:0] exp_mcu(input logic [15:0] a, input logic [15:0] b,
      input bit sa, input bit sb, input bit bt);
    longint p;
    p = ext_val(a, sa, bt) * ext_val(b, sb, bt);
    return bt ? {16'h0, p[15:0]} : p[31:0];
  endfunction

  task automatic check(input string req, input logic [39:0] ea, input logic [31:0] em,
                       input bit ev);
    n_vec++;
    if (acc_res !== ea || mcu_res !== em || res_valid !== ev) begin
      n_bad++;
      $display("FAIL %s: acc=%h mcu=%h vld=%b expected acc=%h mcu=%h vld=%b",
               req, acc_res, mcu_res, res_valid, ea, em, ev);
    end
  endtask

  task automatic apply(input string req, input logic [15:0] a, input logic [15:0] b,
      input bit sa, input bit sb, input bit fr, input bit bt);
    opa = a; opb = b; opa_signed = sa; opb_signed = sb; frac_en = fr; size_byte = bt;
    in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    last_acc = exp_acc(a, b, sa, sb, fr, bt);
    last_mcu = exp_mcu(a, b, sa, sb, bt);
    check(req, last_acc, last_mcu, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: acc=%h mcu=%h expected completion", acc_res, mcu_res);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R3 reset", 40'h0, 32'h0, 1'b0);

    apply("R6 q15 -1 x -1", 16'h8000, 16'h8000, 1, 1, 1, 0);
    if (acc_res !== 40'h0080000000) begin
      n_bad++; $display("FAIL R6: acc=%h expected acc=0080000000", acc_res);
    end
    n_vec++;
    apply("R6 q15 max x max", 16'h7FFF, 16'h7FFF, 1, 1, 1, 0);
    apply("R6 q15 -1 x max", 16'h8000, 16'h7FFF, 1, 1, 1, 0);
    apply("R6 unsigned wrap", 16'hFFFF, 16'hFFFF, 0, 0, 1, 0);
    apply("R4 signed x signed", 16'hFFFF, 16'h0002, 1, 1, 0, 0);
    apply("R4 unsigned x unsigned", 16'hFFFF, 16'hFFFF, 0, 0, 0, 0);
    apply("R4 mixed sign", 16'h8000, 16'hFFFF, 1, 0, 0, 0);
    apply("R7 negative extension", 16'h8000, 16'hFFFF, 1, 0, 0, 0);
    apply("R5 byte signed", 16'hAB80, 16'h12FF, 1, 1, 0, 1);
    apply("R5 byte unsigned", 16'hAB80, 16'h12FF, 0, 0, 0, 1);
    apply("R5 byte upper ignored", 16'h0080, 16'h00FF, 0, 0, 0, 1);
    apply("R8 frac leaves mcu unscaled", 16'h4000, 16'h0003, 1, 1, 1, 0);
    apply("R8 byte frac", 16'h5581, 16'hAA7F, 1, 0, 1, 1);

    // R2: idle cycles with changing operands must not disturb outputs
    for (int i = 0; i < 4; i++) begin
      opa = 16'($urandom); opb = 16'($urandom); frac_en = ~frac_en; size_byte = ~size_byte;
      @(posedge clk); @(negedge clk);
      check("R2 hold while idle", last_acc, last_mcu, 1'b0);
    end

    // R1: back-to-back valid inputs
    for (int i = 0; i < 200; i++) begin
      automatic logic [15:0] a = 16'($urandom);
      automatic logic [15:0] b = 16'($urandom);
      automatic bit sa = 1'($urandom), sb = 1'($urandom);
      automatic bit fr = 1'($urandom), bt = 1'($urandom);
      opa = a; opb = b; opa_signed = sa; opb_signed = sb; frac_en = fr; size_byte = bt;
      in_valid = 1'b1;
      @(posedge clk); @(negedge clk);
      last_acc = exp_acc(a, b, sa, sb, fr, bt);
      last_mcu = exp_mcu(a, b, sa, sb, bt);
      check("R1 R4 R5 R6 R7 R8 random", last_acc, last_mcu, 1'b1);
    end
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 valid drops", last_acc, last_mcu, 1'b0);

    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    check("R3 reset after run", 40'h0, 32'h0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule